// File: doc/BRIEF.md
# Six-Channel ADPCM Key-On Sequencer

The block drives six independent ADPCM sample-playback voices from a byte-wide register write port. Software sets up each voice's start and end addresses, its pan bits and its level. A single write to the global control register then starts or stops any subset of voices at once. A 6-bit mask picks the voices, and bit 7 picks the action: start (0) or stop (1).

The voices share one sample-memory read port and one nibble decoder. A slot counter visits the voices in turn, one per clock. When a playing voice's slot comes round, it decodes one 4-bit code. On the high-nibble visit it reads a fresh byte from memory. On the low-nibble visit it uses the half of that byte it kept. Each code moves a 12-bit signed accumulator by a step that depends on the code's magnitude and on a step-table index, and the code also adjusts that index. A voice stops by itself after it consumes the last byte of its end chunk.

The outputs are each voice's accumulator, forced to zero while the voice is idle, together with left and right enables and the level fields. Mixing, attenuation and the memory itself lie outside the block.

Top module: `adpcm_keyon_seq`

## Requirements
- R1: A write of a byte with bit 7 clear to address 0x00 starts every voice whose bit is set in data bits 5:0, on the clock edge that takes the write. The voice becomes playing, its byte address is loaded with start<<ADDR_SHIFT, its accumulator and step index are cleared, and it begins on the high nibble. Starting a voice that is already playing restarts it.
- R2: A write to address 0x00 with bit 7 set stops the voices selected by data bits 5:0 on that edge and leaves the other voices unchanged.
- R3: For voice c, the 16-bit start address is held in 0x10+c (low byte) and 0x18+c (high byte). The 16-bit end address is held in 0x20+c (low) and 0x28+c (high). The byte address driven on mem_addr_o is the voice's current address, which begins at start<<ADDR_SHIFT.
- R4: The slot counter is 0 after reset and advances 0,1,...,5,0 on each clock. The voice in the current slot, if it is playing and on its high nibble, raises mem_rd_o with its address and decodes mem_data_i bits 7:4. On its next visit it decodes bits 3:0 of that byte and does not read memory.
- R5: Decoding code n with step index i works as follows. delta = ((2*(n&7)+1)*step[i])>>3, using step[] = 16,17,19,21,23,25,28,31,34,37,41,45,50,55,60,66,73,80,88,97,107,118,130,143,157,173,190,209,230,253,279,307,337,371,408,449,494,544,598,658,724,796,876,963,1060,1166,1282,1411,1552. The delta is subtracted if n bit 3 is set and added otherwise, and the accumulator wraps modulo 4096 as 12-bit two's complement. The index then changes by -1,-1,-1,-1,2,5,7,9 for n&7 = 0..7 and is clamped to the range 0..48.
- R6: After decoding the low nibble, a voice whose address equals ((end+1)<<ADDR_SHIFT)-1 stops. Any other voice advances its address by one.
- R7: samp_o slice c holds the accumulator of voice c while it plays and zero otherwise. left_o[c] is playing AND bit 7 of register 0x08+c, and right_o[c] is playing AND bit 6 of that register.
- R8: inst_lvl_o slice c is bits 4:0 of register 0x08+c. total_lvl_o is bits 5:0 of register 0x01.
- R9: Writes to 0x02, to 0x0E/0x0F, and to any address that maps to no register (0x03-0x07, 0x16, 0x30-0x3F and similar) change no output.
- R10: After reset no voice plays, mem_rd_o is low, and all samples, enables and levels are zero.
- R11: mem_rd_o is high only in a cycle where the slot's voice is playing and on its high nibble. At most one voice drives the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 6 | Register address |
| wr_data_i | input | 8 | Register write data |
| mem_rd_o | output | 1 | Sample-memory read strobe |
| mem_addr_o | output | 16+ADDR_SHIFT | Sample-memory byte address |
| mem_data_i | input | 8 | Sample-memory data, combinational from mem_addr_o |
| playing_o | output | 6 | Per-voice playing flags |
| samp_o | output | 72 | Per-voice 12-bit signed sample, voice c at bits 12c+11:12c |
| left_o | output | 6 | Per-voice left enable |
| right_o | output | 6 | Per-voice right enable |
| inst_lvl_o | output | 30 | Per-voice 5-bit level, voice c at bits 5c+4:5c |
| total_lvl_o | output | 6 | Global total level |

## Verification
The in-design assertions check, on every cycle, the local laws of each voice. A start must leave the voice at its start address with a cleared decoder state. A stop must take effect on the next edge. A low-nibble visit must either advance the address by one or stop the voice at the last byte. The step index must stay within its table, at most one voice may read memory, and no enable may be high for an idle voice. The end-to-end behaviour needs the bench's scenarios, which compare against a behavioural model on every clock. Those scenarios cover the decoded sample sequence for real memory contents, round-robin timing, restarts of playing voices, partial-mask stops, the point at which each voice finishes, and the ignored writes.

// File: rtl/adpcm_seq_pkg.sv
package adpcm_seq_pkg;
  localparam int ACC_W  = 12;
  localparam int IDX_W  = 6;
  localparam int IDX_MX = 48;
  localparam int LVL_W  = 5;

  function automatic logic [10:0] step_size(input logic [IDX_W-1:0] i);
    case (i)
      6'd0:  return 11'd16;   6'd1:  return 11'd17;   6'd2:  return 11'd19;
      6'd3:  return 11'd21;   6'd4:  return 11'd23;   6'd5:  return 11'd25;
      6'd6:  return 11'd28;   6'd7:  return 11'd31;   6'd8:  return 11'd34;
      6'd9:  return 11'd37;   6'd10: return 11'd41;   6'd11: return 11'd45;
      6'd12: return 11'd50;   6'd13: return 11'd55;   6'd14: return 11'd60;
      6'd15: return 11'd66;   6'd16: return 11'd73;   6'd17: return 11'd80;
      6'd18: return 11'd88;   6'd19: return 11'd97;   6'd20: return 11'd107;
      6'd21: return 11'd118;  6'd22: return 11'd130;  6'd23: return 11'd143;
      6'd24: return 11'd157;  6'd25: return 11'd173;  6'd26: return 11'd190;
      6'd27: return 11'd209;  6'd28: return 11'd230;  6'd29: return 11'd253;
      6'd30: return 11'd279;  6'd31: return 11'd307;  6'd32: return 11'd337;
      6'd33: return 11'd371;  6'd34: return 11'd408;  6'd35: return 11'd449;
      6'd36: return 11'd494;  6'd37: return 11'd544;  6'd38: return 11'd598;
      6'd39: return 11'd658;  6'd40: return 11'd724;  6'd41: return 11'd796;
      6'd42: return 11'd876;  6'd43: return 11'd963;  6'd44: return 11'd1060;
      6'd45: return 11'd1166; 6'd46: return 11'd1282; 6'd47: return 11'd1411;
      default: return 11'd1552;
    endcase
  endfunction

  function automatic logic signed [4:0] idx_adj(input logic [2:0] m);
    case (m)
      3'd4:    return 5'sd2;
      3'd5:    return 5'sd5;
      3'd6:    return 5'sd7;
      3'd7:    return 5'sd9;
      default: return -5'sd1;
    endcase
  endfunction
endpackage

// File: rtl/adpcm_seq_regs.sv
module adpcm_seq_regs
  import adpcm_seq_pkg::*;
#(
  parameter int N_CH = 6
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic [5:0]            wr_addr_i,
  input  logic [7:0]            wr_data_i,
  output logic [N_CH-1:0]       keyon_o,
  output logic [N_CH-1:0]       dump_o,
  output logic [N_CH-1:0]       pan_l_o,
  output logic [N_CH-1:0]       pan_r_o,
  output logic [N_CH*LVL_W-1:0] lvl_o,
  output logic [5:0]            tl_o,
  output logic [N_CH*16-1:0]    start_o,
  output logic [N_CH*16-1:0]    end_o
);
  logic ctl_hit;
  logic [5:0] tl_q;

  assign ctl_hit = wr_en_i && (wr_addr_i == 6'h00);
  assign keyon_o = (ctl_hit && !wr_data_i[7]) ? wr_data_i[N_CH-1:0] : '0;
  assign dump_o  = (ctl_hit &&  wr_data_i[7]) ? wr_data_i[N_CH-1:0] : '0;
  assign tl_o    = tl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              tl_q <= '0;
    else if (wr_en_i && wr_addr_i == 6'h01)   tl_q <= wr_data_i[5:0];
  end

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    localparam logic [5:0] A_PAN = 6'(8 + c);
    localparam logic [5:0] A_SL  = 6'(16 + c);
    localparam logic [5:0] A_SH  = 6'(24 + c);
    localparam logic [5:0] A_EL  = 6'(32 + c);
    localparam logic [5:0] A_EH  = 6'(40 + c);
    logic [7:0]  pan_q;
    logic [15:0] st_q, en_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pan_q <= '0;
        st_q  <= '0;
        en_q  <= '0;
      end else if (wr_en_i) begin
        if (wr_addr_i == A_PAN) pan_q      <= wr_data_i;
        if (wr_addr_i == A_SL)  st_q[7:0]  <= wr_data_i;
        if (wr_addr_i == A_SH)  st_q[15:8] <= wr_data_i;
        if (wr_addr_i == A_EL)  en_q[7:0]  <= wr_data_i;
        if (wr_addr_i == A_EH)  en_q[15:8] <= wr_data_i;
      end
    end

    assign pan_l_o[c]              = pan_q[7];
    assign pan_r_o[c]              = pan_q[6];
    assign lvl_o[c*LVL_W +: LVL_W] = pan_q[LVL_W-1:0];
    assign start_o[c*16 +: 16]     = st_q;
    assign end_o[c*16 +: 16]       = en_q;
  end

  // R1
  ctl_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (keyon_o & dump_o) == '0);
endmodule

// File: rtl/adpcm_seq_slot.sv
module adpcm_seq_slot #(
  parameter int N_CH = 6,
  localparam int CW = $clog2(N_CH)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  output logic [CW-1:0]   slot_o,
  output logic [N_CH-1:0] sel_o
);
  logic [CW-1:0] slot_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           slot_q <= '0;
    else if (slot_q == CW'(N_CH - 1))      slot_q <= '0;
    else                                   slot_q <= slot_q + 1'b1;
  end

  assign slot_o = slot_q;
  for (genvar c = 0; c < N_CH; c++) begin : g_sel
    assign sel_o[c] = (slot_q == CW'(c));
  end

  // R4
  slot_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot(sel_o));
endmodule

// File: rtl/adpcm_seq_dec.sv
module adpcm_seq_dec
  import adpcm_seq_pkg::*;
(
  input  logic [ACC_W-1:0] acc_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [3:0]       nib_i,
  output logic [ACC_W-1:0] acc_o,
  output logic [IDX_W-1:0] idx_o
);
  logic [10:0]        step;
  logic [14:0]        prod;
  logic [ACC_W-1:0]   delta;
  logic signed [7:0]  idx_sum;

  always_comb begin
    step    = step_size(idx_i);
    prod    = 15'({nib_i[2:0], 1'b1}) * 15'(step);
    delta   = ACC_W'(prod >> 3);
    acc_o   = nib_i[3] ? (acc_i - delta) : (acc_i + delta);
    idx_sum = $signed({2'b00, idx_i}) + 8'(idx_adj(nib_i[2:0]));
    if (idx_sum < 0)                   idx_o = '0;
    else if (idx_sum > 8'sd48)         idx_o = IDX_W'(IDX_MX);
    else                               idx_o = idx_sum[IDX_W-1:0];
  end
endmodule

// File: rtl/adpcm_seq_chan.sv
module adpcm_seq_chan
  import adpcm_seq_pkg::*;
#(
  parameter int ADDR_SHIFT = 8,
  localparam int AW = 16 + ADDR_SHIFT
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sel_i,
  input  logic             keyon_i,
  input  logic             dump_i,
  input  logic [15:0]      start_i,
  input  logic [15:0]      end_i,
  input  logic [7:0]       mem_data_i,
  input  logic [ACC_W-1:0] dec_acc_i,
  input  logic [IDX_W-1:0] dec_idx_i,
  output logic             play_o,
  output logic             fetch_o,
  output logic [AW-1:0]    addr_o,
  output logic [3:0]       nib_o,
  output logic [ACC_W-1:0] acc_o,
  output logic [IDX_W-1:0] idx_o
);
  logic             play_q, nib_q;
  logic [3:0]       lo_q;
  logic [AW-1:0]    addr_q, last_addr;
  logic [ACC_W-1:0] acc_q;
  logic [IDX_W-1:0] idx_q;
  logic             act;

  assign last_addr = {end_i, {ADDR_SHIFT{1'b1}}};
  assign act       = sel_i && play_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      play_q <= 1'b0;
      nib_q  <= 1'b0;
      lo_q   <= '0;
      addr_q <= '0;
      acc_q  <= '0;
      idx_q  <= '0;
    end else if (keyon_i) begin
      play_q <= 1'b1;
      nib_q  <= 1'b0;
      addr_q <= {start_i, {ADDR_SHIFT{1'b0}}};
      acc_q  <= '0;
      idx_q  <= '0;
    end else if (dump_i) begin
      play_q <= 1'b0;
    end else if (act) begin
      acc_q <= dec_acc_i;
      idx_q <= dec_idx_i;
      if (!nib_q) begin
        lo_q  <= mem_data_i[3:0];
        nib_q <= 1'b1;
      end else begin
        nib_q <= 1'b0;
        if (addr_q == last_addr) play_q <= 1'b0;
        else                     addr_q <= addr_q + 1'b1;
      end
    end
  end

  assign play_o  = play_q;
  assign fetch_o = act && !nib_q;
  assign addr_o  = addr_q;
  assign nib_o   = nib_q ? lo_q : mem_data_i[7:4];
  assign acc_o   = acc_q;
  assign idx_o   = idx_q;

  // R1
  keyon_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    keyon_i |=> play_q && !nib_q && acc_q == '0 && idx_q == '0
               && addr_q == $past({start_i, {ADDR_SHIFT{1'b0}}}));
  // R2
  dump_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dump_i && !keyon_i) |=> !play_q);
  // R6
  end_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act && nib_q && !keyon_i && !dump_i && addr_q == last_addr) |=> !play_q);
  // R6
  addr_adv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act && nib_q && !keyon_i && !dump_i && addr_q != last_addr)
      |=> play_q && addr_q == $past(addr_q) + 1'b1);
  // R5
  idx_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_q <= IDX_W'(IDX_MX));
endmodule

// File: rtl/adpcm_keyon_seq.sv
module adpcm_keyon_seq
  import adpcm_seq_pkg::*;
#(
  parameter int N_CH       = 6,
  parameter int ADDR_SHIFT = 8,
  localparam int AW = 16 + ADDR_SHIFT,
  localparam int CW = $clog2(N_CH)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic [5:0]            wr_addr_i,
  input  logic [7:0]            wr_data_i,
  output logic                  mem_rd_o,
  output logic [AW-1:0]         mem_addr_o,
  input  logic [7:0]            mem_data_i,
  output logic [N_CH-1:0]       playing_o,
  output logic [N_CH*ACC_W-1:0] samp_o,
  output logic [N_CH-1:0]       left_o,
  output logic [N_CH-1:0]       right_o,
  output logic [N_CH*LVL_W-1:0] inst_lvl_o,
  output logic [5:0]            total_lvl_o
);
  logic [N_CH-1:0]    keyon, dump, pan_l, pan_r, sel, play, fetch;
  logic [N_CH*16-1:0] start_a, end_a;
  logic [CW-1:0]      slot;
  logic [AW-1:0]      addr_a [N_CH];
  logic [3:0]         nib_a  [N_CH];
  logic [ACC_W-1:0]   acc_a  [N_CH];
  logic [IDX_W-1:0]   idx_a  [N_CH];
  logic [ACC_W-1:0]   dec_acc;
  logic [IDX_W-1:0]   dec_idx;

  adpcm_seq_regs #(.N_CH(N_CH)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .keyon_o(keyon), .dump_o(dump), .pan_l_o(pan_l), .pan_r_o(pan_r),
    .lvl_o(inst_lvl_o), .tl_o(total_lvl_o), .start_o(start_a), .end_o(end_a)
  );

  adpcm_seq_slot #(.N_CH(N_CH)) u_slot (
    .clk_i, .rst_ni, .slot_o(slot), .sel_o(sel)
  );

  // one decoder time-shared across voices by slot
  adpcm_seq_dec u_dec (
    .acc_i(acc_a[slot]), .idx_i(idx_a[slot]), .nib_i(nib_a[slot]),
    .acc_o(dec_acc), .idx_o(dec_idx)
  );

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    adpcm_seq_chan #(.ADDR_SHIFT(ADDR_SHIFT)) u_chan (
      .clk_i, .rst_ni,
      .sel_i(sel[c]), .keyon_i(keyon[c]), .dump_i(dump[c]),
      .start_i(start_a[c*16 +: 16]), .end_i(end_a[c*16 +: 16]),
      .mem_data_i, .dec_acc_i(dec_acc), .dec_idx_i(dec_idx),
      .play_o(play[c]), .fetch_o(fetch[c]), .addr_o(addr_a[c]),
      .nib_o(nib_a[c]), .acc_o(acc_a[c]), .idx_o(idx_a[c])
    );
    assign samp_o[c*ACC_W +: ACC_W] = play[c] ? acc_a[c] : '0;
  end

  always_comb begin
    mem_addr_o = '0;
    for (int c = 0; c < N_CH; c++)
      if (fetch[c]) mem_addr_o = mem_addr_o | addr_a[c];
  end

  assign mem_rd_o  = |fetch;
  assign playing_o = play;
  assign left_o    = play & pan_l;
  assign right_o   = play & pan_r;

  // R11
  single_fetch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(fetch) && (mem_rd_o == (fetch != '0)));
  // R7
  pan_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((left_o | right_o) & ~playing_o) == '0);
  // R10
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (playing_o == '0) |-> (!mem_rd_o && samp_o == '0));
endmodule

// File: tb/sim_adpcm_keyon_seq.sv
module sim_adpcm_keyon_seq;
  localparam int CLK_P = 10;
  localparam int NC    = 6;
  localparam int SH    = 2;
  localparam int AW    = 16 + SH;

  logic clk = 0, rst_ni = 0;
  logic wr_en = 0;
  logic [5:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic mem_rd;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_data;
  logic [NC-1:0] playing, left, right;
  logic [NC*12-1:0] samp;
  logic [NC*5-1:0] ilvl;
  logic [5:0] tlvl;

  int tests = 0, fails = 0;

  always #(CLK_P/2) clk = ~clk;

  function automatic logic [7:0] mem_f(int a);
    return 8'((a * 37 + 11) ^ (a >> 3));
  endfunction
  assign mem_data = mem_f(int'(mem_addr));

  adpcm_keyon_seq #(.N_CH(NC), .ADDR_SHIFT(SH)) u0 (
    .clk_i(clk), .rst_ni, .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .mem_rd_o(mem_rd), .mem_addr_o(mem_addr), .mem_data_i(mem_data),
    .playing_o(playing), .samp_o(samp), .left_o(left), .right_o(right),
    .inst_lvl_o(ilvl), .total_lvl_o(tlvl)
  );

  // behavioural reference
  int steps[49] = '{16,17,19,21,23,25,28,31,34,37,41,45,50,55,60,66,73,80,88,97,
                    107,118,130,143,157,173,190,209,230,253,279,307,337,371,408,
                    449,494,544,598,658,724,796,876,963,1060,1166,1282,1411,1552};
  int adj[8] = '{-1,-1,-1,-1,2,5,7,9};
  int m_play[NC], m_addr[NC], m_nib[NC], m_lo[NC], m_acc[NC], m_idx[NC];
  int m_pan[NC], m_st[NC], m_en[NC], m_tl, m_slot;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int c = 0; c < NC; c++) begin
      m_play[c] = 0; m_addr[c] = 0; m_nib[c] = 0; m_lo[c] = 0;
      m_acc[c] = 0; m_idx[c] = 0; m_pan[c] = 0; m_st[c] = 0; m_en[c] = 0;
    end
    m_tl = 0; m_slot = 0;
  endtask

  task automatic model_step();
    int ko, dm, s, n, d, a;
    ko = (wr_en && wr_addr == 0 && !wr_data[7]) ? int'(wr_data[5:0]) : 0;
    dm = (wr_en && wr_addr == 0 &&  wr_data[7]) ? int'(wr_data[5:0]) : 0;
    for (int c = 0; c < NC; c++) begin
      if (ko[c]) begin
        m_play[c] = 1; m_nib[c] = 0; m_addr[c] = m_st[c] << SH; m_acc[c] = 0; m_idx[c] = 0;
      end else if (dm[c]) begin
        m_play[c] = 0;
      end else if (c == m_slot && m_play[c] != 0) begin
        if (m_nib[c] == 0) begin
          n = int'(mem_f(m_addr[c]) >> 4);
          m_lo[c] = int'(mem_f(m_addr[c]) & 8'hF);
        end else n = m_lo[c];
        d = ((2 * (n & 7) + 1) * steps[m_idx[c]]) >> 3;
        a = (n & 8) ? m_acc[c] - d : m_acc[c] + d;
        a = a & 'hFFF;
        m_acc[c] = (a >= 2048) ? a - 4096 : a;
        m_idx[c] = m_idx[c] + adj[n & 7];
        if (m_idx[c] < 0) m_idx[c] = 0;
        if (m_idx[c] > 48) m_idx[c] = 48;
        if (m_nib[c] == 0) m_nib[c] = 1;
        else begin
          m_nib[c] = 0;
          if (m_addr[c] == ((m_en[c] + 1) << SH) - 1) m_play[c] = 0;
          else m_addr[c] = (m_addr[c] + 1) % (1 << AW);
        end
      end
    end
    if (wr_en) begin
      s = int'(wr_addr);
      if (s == 1) m_tl = int'(wr_data[5:0]);
      for (int c = 0; c < NC; c++) begin
        if (s == 8 + c)  m_pan[c] = int'(wr_data);
        if (s == 16 + c) m_st[c] = (m_st[c] & 'hFF00) | int'(wr_data);
        if (s == 24 + c) m_st[c] = (m_st[c] & 'h00FF) | (int'(wr_data) << 8);
        if (s == 32 + c) m_en[c] = (m_en[c] & 'hFF00) | int'(wr_data);
        if (s == 40 + c) m_en[c] = (m_en[c] & 'h00FF) | (int'(wr_data) << 8);
      end
    end
    m_slot = (m_slot + 1) % NC;
  endtask

  task automatic compare();
    int es, rd;
    for (int c = 0; c < NC; c++) begin
      chk(playing[c] == m_play[c][0], "R1 R2 R6 playing", int'(playing[c]), m_play[c]);
      es = m_play[c] ? m_acc[c] : 0;
      chk(int'($signed(samp[c*12 +: 12])) == es, "R5 R7 sample",
          int'($signed(samp[c*12 +: 12])), es);
      chk(left[c] == (m_play[c] != 0 && m_pan[c][7]), "R7 left", int'(left[c]),
          int'(m_play[c] != 0 && m_pan[c][7]));
      chk(right[c] == (m_play[c] != 0 && m_pan[c][6]), "R7 right", int'(right[c]),
          int'(m_play[c] != 0 && m_pan[c][6]));
      chk(int'(ilvl[c*5 +: 5]) == (m_pan[c] & 'h1F), "R8 inst level",
          int'(ilvl[c*5 +: 5]), m_pan[c] & 'h1F);
    end
    chk(int'(tlvl) == m_tl, "R8 total level", int'(tlvl), m_tl);
    rd = (m_play[m_slot] != 0 && m_nib[m_slot] == 0) ? 1 : 0;
    chk(int'(mem_rd) == rd, "R4 R11 read strobe", int'(mem_rd), rd);
    if (rd != 0)
      chk(int'(mem_addr) == m_addr[m_slot], "R3 R4 read address", int'(mem_addr), m_addr[m_slot]);
  endtask

  always @(posedge clk) begin
    if (!rst_ni) model_reset();
    else model_step();
    #(CLK_P/4);
    compare();
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1; wr_addr = 6'(a); wr_data = 8'(d);
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  int st0[NC] = '{'h0010, 'h0100, 'h0200, 'h1234, 'h0300, 'hFFF0};
  int en0[NC] = '{'h0012, 'h0100, 'h0205, 'h1236, 'h0301, 'hFFF3};
  int pn0[NC] = '{'hDF, 'h8A, 'h45, 'h00, 'hC3, 'h51};

  initial begin
    model_reset();
    idle(3);
    // R10
    chk(playing == '0 && samp == '0 && !mem_rd && ilvl == '0 && tlvl == '0 &&
        left == '0 && right == '0, "R10 reset state", int'(playing), 0);
    @(negedge clk); rst_ni = 1;
    idle(2);
    for (int c = 0; c < NC; c++) begin
      wr(8 + c, pn0[c]);
      wr(16 + c, st0[c] & 'hFF);  wr(24 + c, st0[c] >> 8);
      wr(32 + c, en0[c] & 'hFF);  wr(40 + c, en0[c] >> 8);
    end
    wr(1, 'hEA);
    // R9: test, unused and out-of-range writes
    wr(2, 'hFF); wr(5, 'h77); wr('h0E, 'h9F); wr('h16, 'h33); wr('h3A, 'h55);
    idle(1);
    chk(playing == '0 && samp == '0 && int'(tlvl) == 'h2A &&
        int'(ilvl[0 +: 5]) == 'h1F && int'(ilvl[25 +: 5]) == 'h11,
        "R9 ignored writes", int'(tlvl), 'h2A);
    wr(0, 'h3F);                  // R1 start all
    idle(60);
    wr(0, 'h85);                  // R2 stop voices 0 and 2
    idle(20);
    wr(0, 'h02); wr(0, 'h01);     // R1 restart
    idle(400);
    wr(0, 'h3F);
    idle(30);
    wr(0, 'h10);                  // R1 restart while playing
    idle(40);
    wr(0, 'hA8);                  // R2 stop voices 3 and 5
    idle(700);
    // R6
    chk(playing == '0, "R6 all voices ended", int'(playing), 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(CLK_P * 20000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule